// File: doc/BRIEF.md
# Unsigned Add/Subtract Unit with Magnitude Output

This block is a purely combinational unsigned arithmetic unit for two operands of equal, parameterised width. A single mode pin picks the operation. With the pin low, the block adds the operands and reports the carry out of the top bit.

With the pin high, it forms the difference through a ripple borrow chain. When the final borrow shows that the second operand was larger, a selective two's complementer rewrites the raw difference into the true magnitude. The output is then always the size of the gap between the two operands, and a separate flag marks that the difference was negative.

The complementer scans from the least significant bit upward. It copies every bit up to and including the first 1, then inverts every bit above that one. It does not invert-and-increment.

The block has no clock and no stream traffic. Every port is a plain level, and the outputs follow the inputs after logic settles.

Top module: `addsub_mag`

## Requirements
- R1: With `sub` = 0, `result` equals (m + n) mod 2^WIDTH and `carry_out` equals bit WIDTH of m + n.
- R2: With `sub` = 0, `negative` is 0 for every operand pair.
- R3: With `sub` = 1 and m ≥ n, `result` equals m − n and `negative` is 0.
- R4: With `sub` = 1 and n > m, `result` equals n − m and `negative` is 1.
- R5: With `sub` = 1, `carry_out` is 0 for every operand pair.
- R6: With `sub` = 1 and m = n, `result` is 0 and `negative` is 0.
- R7: When enabled, the complementer returns (2^WIDTH − x) mod 2^WIDTH for an input x. When disabled, it returns x unchanged. Its enable is the final borrow of the subtract chain.
- R8: At WIDTH = 8, subtracting 150 from 100 gives a raw difference of 206 with a final borrow. The unit outputs 50 with `negative` = 1. At WIDTH = 5, 30 − 19 and 19 − 30 both output 11, with `negative` equal to 0 and 1 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m | input | WIDTH | First operand (minuend in subtract mode) |
| n | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub | input | 1 | 0 selects addition, 1 selects magnitude subtraction |
| result | output | WIDTH | Sum, or magnitude of the difference |
| carry_out | output | 1 | Carry out of the adder in add mode, 0 in subtract mode |
| negative | output | 1 | Set in subtract mode when n exceeded m |

## Verification
At four bits, every operand pair is applied in both modes. This exhausts the transition between a borrow-free and a borrowing difference, equal operands, and sums that wrap.

A table of eight-bit vectors targets specific edges. Zero minus all-ones makes the complementer invert every bit above bit 0. An operand of 128 minus 0 leaves the complementer disabled with only the top bit set. The worked 100 − 150 case is also in the table.

Random eight-bit pairs, checked against an integer model, separate a correct scan from one that stops or starts at the wrong bit. Two five-bit cases pin down the symmetric results of 30 − 19 and 19 − 30.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic half;
    assign half         = a[i] ^ b[i];
    assign sum[i]       = half ^ carry[i];
    assign carry[i + 1] = (a[i] & b[i]) | (carry[i] & half);
  end

  assign cout = carry[WIDTH];

  // R1: the ripple chain matches the arithmetic sum
  always_comb begin
    assert_add_sum_R1 : assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + EXT'(cin)))
      else $error("ripple adder sum mismatch");
  end
endmodule

// File: rtl/ripple_sub.sv
module ripple_sub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] diff,
  output logic             bout
);
  logic [WIDTH:0] brw;
  assign brw[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fs
    logic same;
    assign same       = ~(a[i] ^ b[i]);
    assign diff[i]    = ~same ^ brw[i];
    assign brw[i + 1] = (~a[i] & b[i]) | (same & brw[i]);
  end

  assign bout = brw[WIDTH];

  // R3/R4: borrow and raw difference reconstruct the minuend
  always_comb begin
    assert_sub_borrow_R3 : assert (({1'b0, diff} + {1'b0, b}) == {bout, a})
      else $error("borrow chain mismatch");
    assert_sub_order_R4 : assert (bout == (b > a))
      else $error("borrow does not reflect operand order");
  end
endmodule

// File: rtl/sel_twos_comp.sv
module sel_twos_comp #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic             en,
  output logic [WIDTH-1:0] y
);
  // seen[i] is set once a 1 has appeared in a bit below position i
  logic [WIDTH-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_scan
    if (i > 0) begin : g_chain
      assign seen[i] = seen[i - 1] | x[i - 1];
    end
    assign y[i] = (en & seen[i]) ? ~x[i] : x[i];
  end

  // R7: enabled output is the additive inverse, disabled output is a copy
  always_comb begin
    if (en) begin
      assert_comp_inverse_R7 : assert (WIDTH'(x + y) == '0)
        else $error("complement is not additive inverse");
    end else begin
      assert_comp_pass_R7 : assert (y == x)
        else $error("disabled complementer altered data");
    end
  end
endmodule

// File: rtl/addsub_mag.sv
module addsub_mag
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] m,
  input  logic [WIDTH-1:0] n,
  input  logic             sub,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             negative
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic [MSB:0]     sum_w;
  logic             add_c;
  logic [MSB:0]     raw_d;
  logic             fin_b;
  logic [MSB:0]     mag_d;

  assign op = op_e'(sub);

  ripple_add #(.WIDTH(WIDTH)) u_add (
    .a(m), .b(n), .cin(1'b0), .sum(sum_w), .cout(add_c)
  );

  ripple_sub #(.WIDTH(WIDTH)) u_sub (
    .a(m), .b(n), .diff(raw_d), .bout(fin_b)
  );

  sel_twos_comp #(.WIDTH(WIDTH)) u_fix (
    .x(raw_d), .en(fin_b), .y(mag_d)
  );

  always_comb begin
    unique case (op)
      OP_ADD: begin
        result    = sum_w;
        carry_out = add_c;
        negative  = 1'b0;
      end
      OP_SUB: begin
        result    = mag_d;
        carry_out = 1'b0;
        negative  = fin_b;
      end
      default: begin
        result    = sum_w;
        carry_out = add_c;
        negative  = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!sub) begin
      assert_add_positive_R2 : assert (!negative)
        else $error("negative set in add mode");
    end else begin
      assert_sub_no_carry_R5 : assert (!carry_out)
        else $error("carry set in subtract mode");
      if (m == n) begin
        assert_equal_zero_R6 : assert (result == '0 && !negative)
          else $error("equal operands gave non-zero");
      end
      if (negative) begin
        assert_neg_mag_R4 : assert ((result != '0) && (WIDTH'(m + result) == n))
          else $error("negative magnitude inconsistent");
      end else begin
        assert_pos_mag_R3 : assert (WIDTH'(n + result) == m)
          else $error("positive magnitude inconsistent");
      end
    end
  end
endmodule

// File: tb/test_addsub_mag.sv
module test_addsub_mag;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  // four-bit instance
  logic [3:0] m4, n4, r4;
  logic       s4, c4, g4;
  addsub_mag #(.WIDTH(4)) i_addsub_mag (
    .m(m4), .n(n4), .sub(s4), .result(r4), .carry_out(c4), .negative(g4)
  );

  // eight-bit instance
  logic [7:0] m8, n8, r8;
  logic       s8, c8, g8;
  addsub_mag #(.WIDTH(8)) i_addsub_mag_w8 (
    .m(m8), .n(n8), .sub(s8), .result(r8), .carry_out(c8), .negative(g8)
  );

  // five-bit instance
  logic [4:0] m5, n5, r5;
  logic       s5, c5, g5;
  addsub_mag #(.WIDTH(5)) i_addsub_mag_w5 (
    .m(m5), .n(n5), .sub(s5), .result(r5), .carry_out(c5), .negative(g5)
  );

  // {sub, m, n, expected result, expected carry, expected negative}
  localparam int NVEC = 8;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 8'd100, 8'd150, 8'd50,  1'b0, 1'b1},  // R8 worked case
    {1'b1, 8'd150, 8'd100, 8'd50,  1'b0, 1'b0},  // R3
    {1'b0, 8'd200, 8'd100, 8'd44,  1'b1, 1'b0},  // R1 wrap
    {1'b0, 8'd255, 8'd1,   8'd0,   1'b1, 1'b0},  // R1 full carry
    {1'b1, 8'd0,   8'd255, 8'd255, 1'b0, 1'b1},  // R7 long inversion
    {1'b1, 8'd77,  8'd77,  8'd0,   1'b0, 1'b0},  // R6
    {1'b0, 8'd0,   8'd0,   8'd0,   1'b0, 1'b0},  // R2
    {1'b1, 8'd128, 8'd0,   8'd128, 1'b0, 1'b0}   // R7 pass-through
  };

  task automatic check(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests_failed++;
      tests_run++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    m4 = '0; n4 = '0; s4 = 1'b0;
    m8 = '0; n8 = '0; s8 = 1'b0;
    m5 = '0; n5 = '0; s5 = 1'b0;
    @(negedge clk);

    // initial state with zero inputs
    check("R2 init negative", int'(g4), 0);
    check("R1 init result", int'(r4), 0);
    check("R1 init carry", int'(c4), 0);

    // exhaustive four-bit sweep
    for (int md = 0; md < 2; md++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          m4 = 4'(a); n4 = 4'(b); s4 = md[0];
          #5;
          if (md == 0) begin
            check("R1 add result", int'(r4), (a + b) % 16);
            check("R1 add carry", int'(c4), (a + b) / 16);
            check("R2 add negative", int'(g4), 0);
          end else begin
            check("R5 sub carry", int'(c4), 0);
            if (a == b) begin
              check("R6 equal result", int'(r4), 0);
              check("R6 equal negative", int'(g4), 0);
            end else if (a > b) begin
              check("R3 result", int'(r4), a - b);
              check("R3 negative", int'(g4), 0);
            end else begin
              check("R4 result", int'(r4), b - a);
              check("R4 negative", int'(g4), 1);
              // R7: correction equals 2^n minus the raw difference
              check("R7 complement", int'(r4), 16 - ((a - b + 16) % 16));
            end
          end
          @(negedge clk);
        end
      end
    end

    // eight-bit vector table
    for (int k = 0; k < NVEC; k++) begin
      s8 = VEC[k][26];
      m8 = VEC[k][25:18];
      n8 = VEC[k][17:10];
      #5;
      check("R8 table result", int'(r8), int'(VEC[k][9:2]));
      check("R1 table carry", int'(c8), int'(VEC[k][1]));
      check("R4 table negative", int'(g8), int'(VEC[k][0]));
      @(negedge clk);
    end

    // eight-bit random against integer model
    for (int k = 0; k < 400; k++) begin
      int a, b, md;
      a = $urandom_range(255);
      b = $urandom_range(255);
      md = $urandom_range(1);
      m8 = 8'(a); n8 = 8'(b); s8 = md[0];
      #5;
      if (md == 0) begin
        check("R1 rand result", int'(r8), (a + b) % 256);
        check("R1 rand carry", int'(c8), (a + b) / 256);
        check("R2 rand negative", int'(g8), 0);
      end else begin
        check("R3 rand magnitude", int'(r8), (a >= b) ? a - b : b - a);
        check("R4 rand negative", int'(g8), (b > a) ? 1 : 0);
        check("R5 rand carry", int'(c8), 0);
      end
      @(negedge clk);
    end

    // five-bit directed cases
    m5 = 5'd30; n5 = 5'd19; s5 = 1'b1;
    #5;
    check("R8 30-19 result", int'(r5), 11);
    check("R8 30-19 negative", int'(g5), 0);
    @(negedge clk);
    m5 = 5'd19; n5 = 5'd30; s5 = 1'b1;
    #5;
    check("R8 19-30 result", int'(r5), 11);
    check("R8 19-30 negative", int'(g5), 1);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule